// File: doc/BRIEF.md
# PIO Strobe Timing Engine

This block produces the drive-side cycle timing for one channel of a parallel ATA-style disk interface running programmed I/O. A host-side agent presents one request at a time: read or write, whether it targets the 16-bit data register or an 8-bit command-block register, a register address and the write data. The engine then runs the cycle on the drive pins in three phases. The address and chip select are held for a fixed setup time. The read or write strobe is then held active. A recovery gap follows before the next cycle may start. Read data is returned with a one-cycle done pulse, and a write also ends with that pulse.

The lengths of the strobe-active phase and the recovery phase are counted in clock cycles and come from four programmable timing bytes. There is one byte for each combination of read or write and data register or command register. A 4-bit field is enough to reach the slow PIO modes 0 to 2 and the faster mode 3 (about 11 MB/s) at typical clock rates. The engine samples the timing byte when it accepts a request, so software may reprogram it while a cycle is in flight.

Top module: `pio_strobe_engine`

## Requirements
- R1: While reset is asserted and after it is released with no request, busy, drv_cs, drv_rd, drv_wr, drv_oe and rsp_done are all 0.
- R2: A request is accepted on a rising edge where req_valid is 1 and busy is 0. The two cycles that follow are setup: drv_cs is 1, drv_addr holds the request address, and neither strobe is active.
- R3: After setup, the strobe is active (drv_rd for a read, drv_wr for a write) for N cycles, where N is the active field of the selected timing byte and a field of 0 gives 1 cycle. drv_cs stays 1 through the strobe and drops with it.
- R4: After the strobe comes a recovery of M cycles, where M is the recovery field and 0 gives 1 cycle. busy stays 1 from acceptance to the end of recovery. No new cycle starts until busy has been 0 for a cycle.
- R5: Each timing byte holds the active count in bits [3:0] and the recovery count in bits [7:4]. Read cycles use the read byte and write cycles use the write byte.
- R6: Data-register cycles (req_data_reg=1) use cfg_dat_rd or cfg_dat_wr. Command-register cycles (req_data_reg=0) use cfg_cmd_rd or cfg_cmd_wr.
- R7: rsp_done pulses for exactly one cycle, in the first recovery cycle of every read or write. On a read, rsp_rdata in that cycle is drv_din as sampled on the clock edge that ends the strobe.
- R8: A data-register read returns all 16 bits of drv_din. A command-register read returns drv_din[7:0] with bits [15:8] zero.
- R9: On a write, drv_oe is 1 from the first setup cycle to the last strobe cycle and 0 otherwise. While drv_oe is 1, drv_dout carries the write data: all 16 bits for the data register, and req_wdata[7:0] zero-extended for a command register. drv_oe is never 1 on a read.
- R10: The timing byte is sampled at acceptance. Changing it during a cycle does not change that cycle's phase lengths.
- R11: A request presented while busy is 1 is ignored. The running cycle's address, data and timing are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dat_rd | input | 8 | Data-register read timing: [3:0] active, [7:4] recovery |
| cfg_dat_wr | input | 8 | Data-register write timing |
| cfg_cmd_rd | input | 8 | Command-register read timing |
| cfg_cmd_wr | input | 8 | Command-register write timing |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_reg | input | 1 | 1 = data register, 0 = command register |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Cycle in progress, requests ignored |
| drv_cs | output | 1 | Chip select toward the drive |
| drv_addr | output | 3 | Address toward the drive |
| drv_rd | output | 1 | Read strobe, active high |
| drv_wr | output | 1 | Write strobe, active high |
| drv_oe | output | 1 | Enable for the data bus driver |
| drv_dout | output | 16 | Write data toward the drive |
| drv_din | input | 16 | Read data from the drive |
| rsp_done | output | 1 | One-cycle end-of-cycle pulse |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |

## Verification
The bench runs all four kinds of cycle, each with its own timing byte. Because the lengths differ between kinds, a wrong byte selection shows up as a strobe or recovery of the wrong length. Zero fields and all-ones fields test the low and high ends of the counters. Read data from the drive changes on every cycle, so only a capture on the exact edge that ends the strobe returns the expected word. Separate passes change the timing byte during a cycle, hold requests during busy, and issue back-to-back requests. These passes separate correct sampling at acceptance from sampling that is late or happens again.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;
    parameter int TIME_W = 4;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 3;
    parameter int CMD_W  = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } pio_phase_e;
endpackage

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import pio_timing_pkg::*;
#(
    parameter int TW = TIME_W
) (
    input  logic            is_wr,
    input  logic            is_dat,
    input  logic [2*TW-1:0] cfg_dat_rd,
    input  logic [2*TW-1:0] cfg_dat_wr,
    input  logic [2*TW-1:0] cfg_cmd_rd,
    input  logic [2*TW-1:0] cfg_cmd_wr,
    output logic [TW-1:0]   act_len,
    output logic [TW-1:0]   rec_len
);
    logic [2*TW-1:0] pick;

    always_comb begin
        unique case ({is_dat, is_wr})
            2'b11:   pick = cfg_dat_wr;
            2'b10:   pick = cfg_dat_rd;
            2'b01:   pick = cfg_cmd_wr;
            default: pick = cfg_cmd_rd;
        endcase
        // a zero count still gives one clock of the phase
        act_len = (pick[TW-1:0] == '0)    ? TW'(1) : pick[TW-1:0];
        rec_len = (pick[2*TW-1:TW] == '0) ? TW'(1) : pick[2*TW-1:TW];
    end
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pio_timing_pkg::*;
#(
    parameter int TW        = TIME_W,
    parameter int DW        = DATA_W,
    parameter int AW        = ADDR_W,
    parameter int CW        = CMD_W,
    parameter int SETUP_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_data_reg,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [TW-1:0] act_len,
    input  logic [TW-1:0] rec_len,
    input  logic [DW-1:0] drv_din,
    output logic          busy,
    output logic          drv_cs,
    output logic [AW-1:0] drv_addr,
    output logic          drv_rd,
    output logic          drv_wr,
    output logic          drv_oe,
    output logic [DW-1:0] drv_dout,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata
);
    localparam logic [DW-1:0] BYTE_MASK = DW'((64'd1 << CW) - 64'd1);
    localparam logic [TW-1:0] SETUP_LAST = TW'(SETUP_CYC - 1);

    typedef struct packed {
        pio_phase_e    ph;
        logic [TW-1:0] cnt;
        logic          wr;
        logic          dat;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [TW-1:0] act;
        logic [TW-1:0] rec;
        logic [DW-1:0] rdata;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph    = PH_SETUP;
                    s_d.cnt   = SETUP_LAST;
                    s_d.wr    = req_write;
                    s_d.dat   = req_data_reg;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_data_reg ? req_wdata : (req_wdata & BYTE_MASK);
                    s_d.act   = act_len;
                    s_d.rec   = rec_len;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_ACTIVE;
                    s_d.cnt = s_q.act - TW'(1);
                end else begin
                    s_d.cnt = s_q.cnt - TW'(1);
                end
            end
            PH_ACTIVE: begin
                if (s_q.cnt == '0) begin
                    s_d.ph   = PH_RECOV;
                    s_d.cnt  = s_q.rec - TW'(1);
                    s_d.done = 1'b1;
                    if (!s_q.wr)
                        s_d.rdata = s_q.dat ? drv_din : (drv_din & BYTE_MASK);
                end else begin
                    s_d.cnt = s_q.cnt - TW'(1);
                end
            end
            default: begin
                if (s_q.cnt == '0) s_d.ph = PH_IDLE;
                else               s_d.cnt = s_q.cnt - TW'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy      = (s_q.ph != PH_IDLE);
    assign drv_cs    = (s_q.ph == PH_SETUP) || (s_q.ph == PH_ACTIVE);
    assign drv_addr  = s_q.addr;
    assign drv_rd    = (s_q.ph == PH_ACTIVE) && !s_q.wr;
    assign drv_wr    = (s_q.ph == PH_ACTIVE) && s_q.wr;
    assign drv_oe    = s_q.wr && drv_cs;
    assign drv_dout  = s_q.wdata;
    assign rsp_done  = s_q.done;
    assign rsp_rdata = s_q.rdata;

    // R2: a strobe only rises after two clocks of chip select
    a_r2_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_rd || drv_wr) |-> ($past(drv_cs, 1) && $past(drv_cs, 2)));
    // R2: address held while chip select stays asserted
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_cs && $past(drv_cs)) |-> $stable(drv_addr));
    // R7: done is a single pulse that directly follows a strobe
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($past(drv_rd || drv_wr) && !(drv_rd || drv_wr)));
    // R9: write strobe always inside the driven data window
    a_r9_oe_covers_write: assert property (@(posedge clk) disable iff (!rst_n)
        drv_wr |-> drv_oe);
    // R4: chip select never asserted outside a busy interval
    a_r4_cs_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        drv_cs |-> busy);
endmodule

// File: rtl/pio_strobe_engine.sv
module pio_strobe_engine
    import pio_timing_pkg::*;
#(
    parameter int TW        = TIME_W,
    parameter int DW        = DATA_W,
    parameter int AW        = ADDR_W,
    parameter int CW        = CMD_W,
    parameter int SETUP_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2*TW-1:0] cfg_dat_rd,
    input  logic [2*TW-1:0] cfg_dat_wr,
    input  logic [2*TW-1:0] cfg_cmd_rd,
    input  logic [2*TW-1:0] cfg_cmd_wr,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_data_reg,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          drv_cs,
    output logic [AW-1:0] drv_addr,
    output logic          drv_rd,
    output logic          drv_wr,
    output logic          drv_oe,
    output logic [DW-1:0] drv_dout,
    input  logic [DW-1:0] drv_din,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata
);
    logic [TW-1:0] act_len;
    logic [TW-1:0] rec_len;

    pio_timing_sel #(.TW(TW)) u_sel (
        .is_wr      (req_write),
        .is_dat     (req_data_reg),
        .cfg_dat_rd (cfg_dat_rd),
        .cfg_dat_wr (cfg_dat_wr),
        .cfg_cmd_rd (cfg_cmd_rd),
        .cfg_cmd_wr (cfg_cmd_wr),
        .act_len    (act_len),
        .rec_len    (rec_len)
    );

    pio_cycle_seq #(
        .TW(TW), .DW(DW), .AW(AW), .CW(CW), .SETUP_CYC(SETUP_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_data_reg (req_data_reg),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .act_len      (act_len),
        .rec_len      (rec_len),
        .drv_din      (drv_din),
        .busy         (busy),
        .drv_cs       (drv_cs),
        .drv_addr     (drv_addr),
        .drv_rd       (drv_rd),
        .drv_wr       (drv_wr),
        .drv_oe       (drv_oe),
        .drv_dout     (drv_dout),
        .rsp_done     (rsp_done),
        .rsp_rdata    (rsp_rdata)
    );
endmodule

// File: tb/pio_strobe_engine_test.sv
module pio_strobe_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_dat_rd = 8'h0, cfg_dat_wr = 8'h0, cfg_cmd_rd = 8'h0, cfg_cmd_wr = 8'h0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_data_reg = 1'b0;
    logic [2:0]  req_addr = 3'd0;
    logic [15:0] req_wdata = 16'h0;
    logic [15:0] drv_din = 16'h0;
    logic        busy, drv_cs, drv_rd, drv_wr, drv_oe, rsp_done;
    logic [2:0]  drv_addr;
    logic [15:0] drv_dout, rsp_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string ctx = "base";

    pio_strobe_engine uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_dat_rd(cfg_dat_rd), .cfg_dat_wr(cfg_dat_wr),
        .cfg_cmd_rd(cfg_cmd_rd), .cfg_cmd_wr(cfg_cmd_wr),
        .req_valid(req_valid), .req_write(req_write), .req_data_reg(req_data_reg),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .drv_cs(drv_cs), .drv_addr(drv_addr),
        .drv_rd(drv_rd), .drv_wr(drv_wr), .drv_oe(drv_oe), .drv_dout(drv_dout),
        .drv_din(drv_din), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s [%s] cycle %0d actual=%h expected=%h", what, ctx, cyc, act, exp);
        end
    endtask

    // reference model: age counts clocks since acceptance, 0 = idle
    int          age = 0;
    int          m_act = 1, m_rec = 1;
    bit          m_wr = 0, m_dat = 0;
    logic [2:0]  m_addr = 0;
    logic [15:0] m_wdata = 0, m_rdata = 0;

    function automatic int floor1(input logic [3:0] v);
        return (v == 4'd0) ? 1 : int'(v);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            age = 0;
        end else begin
            if (age == 0) begin
                if (req_valid) begin
                    logic [7:0] t;
                    age = 1;
                    m_wr = req_write; m_dat = req_data_reg;
                    m_addr = req_addr;
                    m_wdata = req_data_reg ? req_wdata : {8'h00, req_wdata[7:0]};
                    if (req_data_reg) t = req_write ? cfg_dat_wr : cfg_dat_rd;
                    else              t = req_write ? cfg_cmd_wr : cfg_cmd_rd;
                    m_act = floor1(t[3:0]);
                    m_rec = floor1(t[7:4]);
                end
            end else if (age == 2 + m_act + m_rec) begin
                age = 0;
            end else begin
                age = age + 1;
            end
            if (age == 3 + m_act && !m_wr)
                m_rdata = m_dat ? drv_din : {8'h00, drv_din[7:0]};
        end
    end

    // drive data changes every clock so the capture edge is visible
    always @(negedge clk) drv_din <= 16'hA500 ^ 16'(cyc * 16'h0131);

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_cs, e_str, e_oe, e_done;
            e_cs   = (age >= 1) && (age <= 2 + m_act);
            e_str  = (age >= 3) && (age <= 2 + m_act);
            e_oe   = m_wr && e_cs;
            e_done = (age == 3 + m_act);
            chk(busy == (age != 0), "R4 busy", 16'(busy), 16'(age != 0));
            chk(drv_cs == e_cs, "R2 R3 chip select", 16'(drv_cs), 16'(e_cs));
            if (e_cs) chk(drv_addr == m_addr, "R2 R11 address", 16'(drv_addr), 16'(m_addr));
            chk(drv_rd == (e_str && !m_wr), "R3 R5 R6 R10 read strobe", 16'(drv_rd), 16'(e_str && !m_wr));
            chk(drv_wr == (e_str && m_wr), "R3 R5 R6 R10 write strobe", 16'(drv_wr), 16'(e_str && m_wr));
            chk(drv_oe == e_oe, "R9 bus enable", 16'(drv_oe), 16'(e_oe));
            if (e_oe) chk(drv_dout == m_wdata, "R9 R11 write data", drv_dout, m_wdata);
            chk(rsp_done == e_done, "R7 done pulse", 16'(rsp_done), 16'(e_done));
            if (e_done && !m_wr) chk(rsp_rdata == m_rdata, "R7 R8 read data", rsp_rdata, m_rdata);
        end
    end

    task automatic issue(input bit wr, input bit dat, input logic [2:0] a, input logic [15:0] wd);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_data_reg = dat; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        ctx = "R1";
        chk(!busy && !drv_cs && !drv_rd && !drv_wr && !drv_oe && !rsp_done,
            "R1 outputs in reset", {10'd0, busy, drv_cs, drv_rd, drv_wr, drv_oe, rsp_done}, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !drv_cs && !rsp_done, "R1 idle after reset",
            {13'd0, busy, drv_cs, rsp_done}, 16'h0);

        // distinct lengths per byte so a wrong selection is visible (R5, R6)
        cfg_dat_rd = 8'h23; cfg_dat_wr = 8'h14; cfg_cmd_rd = 8'h00; cfg_cmd_wr = 8'hFF;
        ctx = "R5 R6 data read";   issue(0, 1, 3'd0, 16'h0000); drain();
        ctx = "R5 R6 data write";  issue(1, 1, 3'd0, 16'hBEEF); drain();
        ctx = "R3 R8 cmd read zero fields"; issue(0, 0, 3'd7, 16'h0000); drain();
        ctx = "R9 cmd write max fields";    issue(1, 0, 3'd2, 16'h12C4); drain();

        ctx = "R10";
        issue(0, 1, 3'd0, 16'h0);
        cfg_dat_rd = 8'h11;
        drain();
        issue(0, 1, 3'd0, 16'h0); drain();

        ctx = "R11";
        issue(1, 1, 3'd0, 16'h5A5A);
        req_valid = 1'b1; req_write = 1'b0; req_data_reg = 1'b0; req_addr = 3'd5; req_wdata = 16'hFFFF;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        drain();

        ctx = "R4 back to back";
        cfg_cmd_rd = 8'h32; cfg_cmd_wr = 8'h21;
        for (int i = 0; i < 6; i++)
            issue(i[0], i[1], 3'(i), 16'h3C00 + 16'(i));
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired [%s] actual=running expected=finished", ctx);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule